// File: doc/BRIEF.md
# Segment Descriptor Cache with Access Check

This block keeps the hidden part of the segment machinery: for each of four program segments (ES, CS, SS, DS) and four system tables (global table, local table, interrupt table, task state), a 24-bit base, a 16-bit limit, an 8-bit rights byte and the 16-bit selector last loaded. The address unit feeds it segment loads. A load in real mode derives the base from the selector. A load in protected mode takes base, limit and rights from a descriptor that was already fetched. A state-restore engine can also overwrite any entry whole, with raw values.

Each cycle the block can take one memory access request: an entry, a 16-bit offset and an access length of 1 to 4 bytes. One cycle later it returns either a 24-bit linear address or a fault. The fault covers an invalid segment and a limit violation, including expand-down data segments. The current privilege level is reported all the time, taken from the stack segment's rights byte.

Top module: `segcache_unit`

## Requirements
- R1: Entries are indexed 0=ES, 1=CS, 2=SS, 3=DS, 4=GDT, 5=LDT, 6=IDT, 7=TSS. The read port shows the selected entry's selector, base, limit and rights combinationally. Rights bits are: 7 valid, 6:5 DPL, 4 unused, 3 code, 2 expand-down/conforming, 1 writable/readable, 0 accessed.
- R2: A load with pmode_i low sets the base to the selector shifted left by 4, sets rights to 82h, stores the selector and leaves the limit unchanged. The result is visible after the clock edge.
- R3: A load with pmode_i high stores the descriptor base, limit and selector, and the descriptor rights with bit 0 forced to 1.
- R4: cpl_o always equals bits 6:5 of the SS rights byte.
- R5: A restore write stores selector, base, limit and rights unmodified. When a restore and a load arrive in the same cycle, the restore is applied and the load is dropped.
- R6: GDT, IDT and TSS always read rights FFh. LDT reads its stored bit 7, with bits 6:0 as 1.
- R7: After reset, ES, SS and DS hold selector 0000h, base 000000h, limit FFFFh and rights 82h. CS holds selector F000h, base FF0000h, limit FFFFh and rights 82h. IDT holds base 0 and limit FFFFh. cpl_o is 0.
- R8: An access through entries 0 to 3 or LDT whose valid bit is 0 faults. GDT, IDT and TSS never fault for validity.
- R9: acc_len_i gives the length minus 1. Outside the expand-down case, including TSS, an access faults when offset + acc_len_i exceeds the limit.
- R10: For entries 0 to 3 with rights bit 3 = 0 and bit 2 = 1 (expand-down data), an access faults when offset <= limit. A code segment (bit 3 = 1) is always checked as expand-up.
- R11: A request accepted at a clock edge gives acc_vld_o high in the next cycle. acc_lin_o is then (base + offset) mod 2^24 when acc_fault_o is low, and 0 when it is high. The check uses the cache contents from before any write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmode_i | input | 1 | Protected mode in effect for loads |
| ld_en_i | input | 1 | Segment load strobe |
| ld_idx_i | input | 3 | Entry to load |
| ld_selector_i | input | 16 | Selector being loaded |
| ld_base_i | input | 24 | Descriptor base (protected mode) |
| ld_limit_i | input | 16 | Descriptor limit (protected mode) |
| ld_rights_i | input | 8 | Descriptor rights (protected mode) |
| rs_en_i | input | 1 | State-restore write strobe |
| rs_idx_i | input | 3 | Entry to restore |
| rs_selector_i | input | 16 | Restored selector |
| rs_base_i | input | 24 | Restored base |
| rs_limit_i | input | 16 | Restored limit |
| rs_rights_i | input | 8 | Restored rights |
| acc_en_i | input | 1 | Access request |
| acc_idx_i | input | 3 | Entry used by the access |
| acc_off_i | input | 16 | Access offset |
| acc_len_i | input | 2 | Access length minus 1 |
| acc_vld_o | output | 1 | Access result valid |
| acc_fault_o | output | 1 | Access faulted |
| acc_lin_o | output | 24 | Linear address |
| rd_idx_i | input | 3 | Entry on the read port |
| rd_selector_o | output | 16 | Selector of read entry |
| rd_base_o | output | 24 | Base of read entry |
| rd_limit_o | output | 16 | Limit of read entry |
| rd_rights_o | output | 8 | Rights of read entry as seen |
| cpl_o | output | 2 | Current privilege level |

## Verification
A wrong cache field shows on the read port right after the clock edge that wrote it. On the access path it shows one cycle later, as a wrong linear address or a wrong fault decision. A corrupted SS rights byte shows on cpl_o in the same cycle. The limit checks are probed on both sides of each boundary, at every access length that crosses it. This way an off-by-one in the comparison, or an expand-down decode applied to the wrong segment, turns into a fault flag of the wrong polarity on the very next result.

// File: rtl/segcache_pkg.sv
`timescale 1ns/1ps
package segcache_pkg;
  localparam int NENT  = 8;
  localparam int IDX_W = $clog2(NENT);

  localparam logic [IDX_W-1:0] IX_ES  = 3'd0;
  localparam logic [IDX_W-1:0] IX_CS  = 3'd1;
  localparam logic [IDX_W-1:0] IX_SS  = 3'd2;
  localparam logic [IDX_W-1:0] IX_DS  = 3'd3;
  localparam logic [IDX_W-1:0] IX_GDT = 3'd4;
  localparam logic [IDX_W-1:0] IX_LDT = 3'd5;
  localparam logic [IDX_W-1:0] IX_IDT = 3'd6;
  localparam logic [IDX_W-1:0] IX_TSS = 3'd7;

  localparam logic [7:0] RM_RIGHTS = 8'h82;

  // Tables without any rights byte of their own
  function automatic logic no_rights(input logic [IDX_W-1:0] idx);
    return (idx == IX_GDT) || (idx == IX_IDT) || (idx == IX_TSS);
  endfunction

  // Program segments (ES..DS)
  function automatic logic is_prog(input logic [IDX_W-1:0] idx);
    return idx < IX_GDT;
  endfunction

  // Rights byte as seen by software and by the checker
  function automatic logic [7:0] view_rights(input logic [IDX_W-1:0] idx,
                                             input logic [7:0] raw);
    logic [7:0] v;
    if (no_rights(idx))      v = 8'hFF;
    else if (idx == IX_LDT)  v = {raw[7], 7'h7F};
    else                     v = raw;
    return v;
  endfunction
endpackage

// File: rtl/segcache_wrmux.sv
`timescale 1ns/1ps
module segcache_wrmux
  import segcache_pkg::*;
#(
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16,
  parameter int SEL_W  = 16
) (
  input  logic              pmode_i,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [SEL_W-1:0]  ld_selector_i,
  input  logic [BASE_W-1:0] ld_base_i,
  input  logic [LIM_W-1:0]  ld_limit_i,
  input  logic [7:0]        ld_rights_i,
  input  logic              rs_en_i,
  input  logic [IDX_W-1:0]  rs_idx_i,
  input  logic [SEL_W-1:0]  rs_selector_i,
  input  logic [BASE_W-1:0] rs_base_i,
  input  logic [LIM_W-1:0]  rs_limit_i,
  input  logic [7:0]        rs_rights_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic [BASE_W-1:0] wr_base_o,
  output logic [LIM_W-1:0]  wr_limit_o,
  output logic              wr_limit_en_o,
  output logic [7:0]        wr_rights_o
);
  localparam int SHIFTED_W = SEL_W + 4;

  logic [SHIFTED_W-1:0] rm_base_wide;
  assign rm_base_wide = {ld_selector_i, 4'h0};

  always_comb begin
    wr_en_o       = rs_en_i | ld_en_i;
    wr_idx_o      = ld_idx_i;
    wr_sel_o      = ld_selector_i;
    wr_base_o     = ld_base_i;
    wr_limit_o    = ld_limit_i;
    wr_limit_en_o = 1'b1;
    wr_rights_o   = ld_rights_i | 8'h01;
    if (rs_en_i) begin
      // restore has priority and is stored raw
      wr_idx_o    = rs_idx_i;
      wr_sel_o    = rs_selector_i;
      wr_base_o   = rs_base_i;
      wr_limit_o  = rs_limit_i;
      wr_rights_o = rs_rights_i;
    end else if (!pmode_i) begin
      wr_base_o     = BASE_W'(rm_base_wide);
      wr_limit_en_o = 1'b0;
      wr_rights_o   = RM_RIGHTS;
    end
  end
endmodule

// File: rtl/segcache_regs.sv
`timescale 1ns/1ps
module segcache_regs
  import segcache_pkg::*;
#(
  parameter int                BASE_W      = 24,
  parameter int                LIM_W       = 16,
  parameter int                SEL_W       = 16,
  parameter logic [SEL_W-1:0]  RST_CS_SEL  = 16'hF000,
  parameter logic [BASE_W-1:0] RST_CS_BASE = 24'hFF0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  logic [LIM_W-1:0]  wr_limit_i,
  input  logic              wr_limit_en_i,
  input  logic [7:0]        wr_rights_i,
  output logic [SEL_W-1:0]  sel_q    [NENT],
  output logic [BASE_W-1:0] base_q   [NENT],
  output logic [LIM_W-1:0]  limit_q  [NENT],
  output logic [7:0]        rights_q [NENT]
);
  for (genvar g = 0; g < NENT; g++) begin : g_ent
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    // GDT, LDT and TSS caches keep their contents across reset
    localparam bit KEEP = (GI == IX_GDT) || (GI == IX_LDT) || (GI == IX_TSS);
    localparam logic [SEL_W-1:0]  SEL_RV  = (GI == IX_CS) ? RST_CS_SEL  : '0;
    localparam logic [BASE_W-1:0] BASE_RV = (GI == IX_CS) ? RST_CS_BASE : '0;

    logic              hit, lim_we;
    logic [SEL_W-1:0]  sel_r,  sel_d;
    logic [BASE_W-1:0] base_r, base_d;
    logic [LIM_W-1:0]  lim_r,  lim_d;
    logic [7:0]        rt_r,   rt_d;

    always_comb begin
      hit    = wr_en_i && (wr_idx_i == GI);
      lim_we = hit && wr_limit_en_i;
      sel_d  = hit    ? wr_sel_i    : sel_r;
      base_d = hit    ? wr_base_i   : base_r;
      lim_d  = lim_we ? wr_limit_i  : lim_r;
      rt_d   = hit    ? wr_rights_i : rt_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_r <= SEL_RV;
      else        sel_r <= sel_d;
    end

    if (KEEP) begin : g_keep
      always_ff @(posedge clk) begin
        base_r <= base_d;
        lim_r  <= lim_d;
        rt_r   <= rt_d;
      end
    end else begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          base_r <= BASE_RV;
          lim_r  <= '1;
          rt_r   <= RM_RIGHTS;
        end else begin
          base_r <= base_d;
          lim_r  <= lim_d;
          rt_r   <= rt_d;
        end
      end
    end

    assign sel_q[g]    = sel_r;
    assign base_q[g]   = base_r;
    assign limit_q[g]  = lim_r;
    assign rights_q[g] = rt_r;
  end
endmodule

// File: rtl/segcache_chk.sv
`timescale 1ns/1ps
module segcache_chk
  import segcache_pkg::*;
#(
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en_i,
  input  logic [IDX_W-1:0]  acc_idx_i,
  input  logic [LIM_W-1:0]  acc_off_i,
  input  logic [1:0]        acc_len_i,
  input  logic [BASE_W-1:0] seg_base_i,
  input  logic [LIM_W-1:0]  seg_limit_i,
  input  logic [7:0]        seg_rights_i,
  output logic              acc_vld_o,
  output logic              acc_fault_o,
  output logic [BASE_W-1:0] acc_lin_o
);
  logic [LIM_W:0]    last_byte;
  logic              past_top, exp_down, lim_fault, inval, fault_d;
  logic [BASE_W-1:0] lin_d;

  always_comb begin
    last_byte = {1'b0, acc_off_i} + (LIM_W+1)'(acc_len_i);
    past_top  = last_byte > {1'b0, seg_limit_i};
    exp_down  = is_prog(acc_idx_i) && !seg_rights_i[3] && seg_rights_i[2];
    lim_fault = exp_down ? (acc_off_i <= seg_limit_i) : past_top;
    inval     = !no_rights(acc_idx_i) && !seg_rights_i[7];
    fault_d   = inval || lim_fault;
    lin_d     = fault_d ? '0 : (seg_base_i + BASE_W'(acc_off_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_vld_o   <= 1'b0;
      acc_fault_o <= 1'b0;
      acc_lin_o   <= '0;
    end else begin
      acc_vld_o <= acc_en_i;
      if (acc_en_i) begin
        acc_fault_o <= fault_d;
        acc_lin_o   <= lin_d;
      end
    end
  end

  // R8: an invalid program segment or local table always faults
  p_invalid_faults_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_en_i && !no_rights(acc_idx_i) && !seg_rights_i[7]) |-> acc_fault_o);

  // R11: a result appears one cycle after each request
  p_result_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_en_i) |-> acc_vld_o);

  // R11: no linear address is presented together with a fault
  p_no_lin_on_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld_o && acc_fault_o) |-> (acc_lin_o == '0));

  // R9: a faulting system table access was out of its limit
  p_sys_fault_is_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_en_i && no_rights(acc_idx_i)) && acc_fault_o) |->
      $past(({1'b0, acc_off_i} + (LIM_W+1)'(acc_len_i)) > {1'b0, seg_limit_i}));
endmodule

// File: rtl/segcache_unit.sv
`timescale 1ns/1ps
module segcache_unit
  import segcache_pkg::*;
#(
  parameter int                BASE_W      = 24,
  parameter int                LIM_W       = 16,
  parameter int                SEL_W       = 16,
  parameter logic [SEL_W-1:0]  RST_CS_SEL  = 16'hF000,
  parameter logic [BASE_W-1:0] RST_CS_BASE = 24'hFF0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pmode_i,
  input  logic              ld_en_i,
  input  logic [2:0]        ld_idx_i,
  input  logic [SEL_W-1:0]  ld_selector_i,
  input  logic [BASE_W-1:0] ld_base_i,
  input  logic [LIM_W-1:0]  ld_limit_i,
  input  logic [7:0]        ld_rights_i,
  input  logic              rs_en_i,
  input  logic [2:0]        rs_idx_i,
  input  logic [SEL_W-1:0]  rs_selector_i,
  input  logic [BASE_W-1:0] rs_base_i,
  input  logic [LIM_W-1:0]  rs_limit_i,
  input  logic [7:0]        rs_rights_i,
  input  logic              acc_en_i,
  input  logic [2:0]        acc_idx_i,
  input  logic [LIM_W-1:0]  acc_off_i,
  input  logic [1:0]        acc_len_i,
  output logic              acc_vld_o,
  output logic              acc_fault_o,
  output logic [BASE_W-1:0] acc_lin_o,
  input  logic [2:0]        rd_idx_i,
  output logic [SEL_W-1:0]  rd_selector_o,
  output logic [BASE_W-1:0] rd_base_o,
  output logic [LIM_W-1:0]  rd_limit_o,
  output logic [7:0]        rd_rights_o,
  output logic [1:0]        cpl_o
);
  logic              wr_en, wr_limit_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [SEL_W-1:0]  wr_sel;
  logic [BASE_W-1:0] wr_base;
  logic [LIM_W-1:0]  wr_limit;
  logic [7:0]        wr_rights;

  logic [SEL_W-1:0]  sel_q    [NENT];
  logic [BASE_W-1:0] base_q   [NENT];
  logic [LIM_W-1:0]  limit_q  [NENT];
  logic [7:0]        rights_q [NENT];

  logic [7:0]        acc_rights;

  segcache_wrmux #(.BASE_W(BASE_W), .LIM_W(LIM_W), .SEL_W(SEL_W)) wrmux_i (
    .pmode_i       (pmode_i),
    .ld_en_i       (ld_en_i),
    .ld_idx_i      (ld_idx_i),
    .ld_selector_i (ld_selector_i),
    .ld_base_i     (ld_base_i),
    .ld_limit_i    (ld_limit_i),
    .ld_rights_i   (ld_rights_i),
    .rs_en_i       (rs_en_i),
    .rs_idx_i      (rs_idx_i),
    .rs_selector_i (rs_selector_i),
    .rs_base_i     (rs_base_i),
    .rs_limit_i    (rs_limit_i),
    .rs_rights_i   (rs_rights_i),
    .wr_en_o       (wr_en),
    .wr_idx_o      (wr_idx),
    .wr_sel_o      (wr_sel),
    .wr_base_o     (wr_base),
    .wr_limit_o    (wr_limit),
    .wr_limit_en_o (wr_limit_en),
    .wr_rights_o   (wr_rights)
  );

  segcache_regs #(
    .BASE_W(BASE_W), .LIM_W(LIM_W), .SEL_W(SEL_W),
    .RST_CS_SEL(RST_CS_SEL), .RST_CS_BASE(RST_CS_BASE)
  ) regs_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en),
    .wr_idx_i      (wr_idx),
    .wr_sel_i      (wr_sel),
    .wr_base_i     (wr_base),
    .wr_limit_i    (wr_limit),
    .wr_limit_en_i (wr_limit_en),
    .wr_rights_i   (wr_rights),
    .sel_q         (sel_q),
    .base_q        (base_q),
    .limit_q       (limit_q),
    .rights_q      (rights_q)
  );

  assign acc_rights = view_rights(acc_idx_i, rights_q[acc_idx_i]);

  segcache_chk #(.BASE_W(BASE_W), .LIM_W(LIM_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_en_i     (acc_en_i),
    .acc_idx_i    (acc_idx_i),
    .acc_off_i    (acc_off_i),
    .acc_len_i    (acc_len_i),
    .seg_base_i   (base_q[acc_idx_i]),
    .seg_limit_i  (limit_q[acc_idx_i]),
    .seg_rights_i (acc_rights),
    .acc_vld_o    (acc_vld_o),
    .acc_fault_o  (acc_fault_o),
    .acc_lin_o    (acc_lin_o)
  );

  assign rd_selector_o = sel_q[rd_idx_i];
  assign rd_base_o     = base_q[rd_idx_i];
  assign rd_limit_o    = limit_q[rd_idx_i];
  assign rd_rights_o   = view_rights(rd_idx_i, rights_q[rd_idx_i]);
  assign cpl_o         = rights_q[IX_SS][6:5];

  // R2: a real-mode load leaves the fixed rights byte
  p_rm_rights_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_en_i && !rs_en_i && !pmode_i) |-> (rights_q[$past(ld_idx_i)] == RM_RIGHTS));

  // R3: a protected-mode load leaves the accessed bit set
  p_pm_accessed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_en_i && !rs_en_i && pmode_i) |-> rights_q[$past(ld_idx_i)][0]);

  // R4: loading SS in protected mode moves the privilege level to its DPL
  p_cpl_from_ss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_en_i && !rs_en_i && pmode_i && (ld_idx_i == IX_SS)) |->
      (cpl_o == $past(ld_rights_i[6:5])));

  // R5: a restore stores its base untouched even when a load competes
  p_restore_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rs_en_i) |-> (base_q[$past(rs_idx_i)] == $past(rs_base_i)));
endmodule

// File: tb/segcache_unit_tb_top.sv
`timescale 1ns/1ps
module segcache_unit_tb_top;
  logic        clk, rst_n, pmode_i;
  logic        ld_en_i, rs_en_i, acc_en_i;
  logic [2:0]  ld_idx_i, rs_idx_i, acc_idx_i, rd_idx_i;
  logic [15:0] ld_selector_i, rs_selector_i, ld_limit_i, rs_limit_i, acc_off_i;
  logic [23:0] ld_base_i, rs_base_i;
  logic [7:0]  ld_rights_i, rs_rights_i;
  logic [1:0]  acc_len_i;
  logic        acc_vld_o, acc_fault_o;
  logic [23:0] acc_lin_o, rd_base_o;
  logic [15:0] rd_selector_o, rd_limit_o;
  logic [7:0]  rd_rights_o;
  logic [1:0]  cpl_o;

  int n_chk  = 0;
  int n_fail = 0;

  segcache_unit dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_restore(input logic [2:0] idx, input logic [15:0] sel,
                            input logic [23:0] base, input logic [15:0] lim,
                            input logic [7:0] rt);
    rs_en_i = 1'b1; rs_idx_i = idx; rs_selector_i = sel;
    rs_base_i = base; rs_limit_i = lim; rs_rights_i = rt;
    tick();
    rs_en_i = 1'b0;
  endtask

  task automatic do_load(input logic pm, input logic [2:0] idx, input logic [15:0] sel,
                         input logic [23:0] base, input logic [15:0] lim,
                         input logic [7:0] rt);
    pmode_i = pm; ld_en_i = 1'b1; ld_idx_i = idx; ld_selector_i = sel;
    ld_base_i = base; ld_limit_i = lim; ld_rights_i = rt;
    tick();
    ld_en_i = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [2:0] idx,
                          input logic [15:0] sel, input logic [23:0] base,
                          input logic [15:0] lim, input logic [7:0] rt);
    rd_idx_i = idx; #1;
    chk({tag, " selector"}, 32'(rd_selector_o), 32'(sel));
    chk({tag, " base"},     32'(rd_base_o),     32'(base));
    chk({tag, " limit"},    32'(rd_limit_o),    32'(lim));
    chk({tag, " rights"},   32'(rd_rights_o),   32'(rt));
  endtask

  task automatic access_chk(input string tag, input logic [2:0] idx,
                            input logic [15:0] off, input logic [1:0] len,
                            input logic exp_fault, input logic [23:0] exp_lin);
    acc_en_i = 1'b1; acc_idx_i = idx; acc_off_i = off; acc_len_i = len;
    tick();
    acc_en_i = 1'b0;
    chk({tag, " valid"}, 32'(acc_vld_o),   32'h1);
    chk({tag, " fault"}, 32'(acc_fault_o), 32'(exp_fault));
    chk({tag, " lin"},   32'(acc_lin_o),   32'(exp_lin));
  endtask

  // R7 R6 R4 R1: values right after reset
  task automatic t_reset();
    read_chk("R7 ES", 3'd0, 16'h0000, 24'h000000, 16'hFFFF, 8'h82);
    read_chk("R7 CS", 3'd1, 16'hF000, 24'hFF0000, 16'hFFFF, 8'h82);
    read_chk("R7 SS", 3'd2, 16'h0000, 24'h000000, 16'hFFFF, 8'h82);
    read_chk("R7 DS", 3'd3, 16'h0000, 24'h000000, 16'hFFFF, 8'h82);
    read_chk("R7 IDT", 3'd6, 16'h0000, 24'h000000, 16'hFFFF, 8'hFF);
    chk("R4 cpl after reset", 32'(cpl_o), 32'h0);
    chk("R1 acc idle", 32'(acc_vld_o), 32'h0);
  endtask

  // R2 R5: real-mode load keeps restored limit
  task automatic t_real_load();
    do_restore(3'd3, 16'h0000, 24'h0, 16'h1234, 8'h92);
    do_load(1'b0, 3'd3, 16'h1234, 24'hABCDEF, 16'h0001, 8'h00);
    read_chk("R2 DS real load", 3'd3, 16'h1234, 24'h012340, 16'h1234, 8'h82);
    do_load(1'b0, 3'd0, 16'hFFFF, 24'h0, 16'h0, 8'hFF);
    read_chk("R2 ES real load", 3'd0, 16'hFFFF, 24'hFFFF0, 16'hFFFF, 8'h82);
  endtask

  // R3 R4: protected-mode loads
  task automatic t_pm_load();
    do_load(1'b1, 3'd2, 16'h002B, 24'h123456, 16'h00FF, 8'hE2);
    read_chk("R3 SS pm load", 3'd2, 16'h002B, 24'h123456, 16'h00FF, 8'hE3);
    chk("R4 cpl dpl3", 32'(cpl_o), 32'h3);
    do_load(1'b1, 3'd2, 16'h0010, 24'h000100, 16'hFFFF, 8'hC0);
    read_chk("R3 SS pm load 2", 3'd2, 16'h0010, 24'h000100, 16'hFFFF, 8'hC1);
    chk("R4 cpl dpl2", 32'(cpl_o), 32'h2);
    do_load(1'b0, 3'd2, 16'h0000, 24'h0, 16'h0, 8'h00);
    chk("R4 cpl after real load", 32'(cpl_o), 32'h0);
    pmode_i = 1'b0;
  endtask

  // R5: restore beats a load in the same cycle
  task automatic t_priority();
    pmode_i = 1'b1;
    ld_en_i = 1'b1; ld_idx_i = 3'd0; ld_selector_i = 16'h1111;
    ld_base_i = 24'h111111; ld_limit_i = 16'h1111; ld_rights_i = 8'h90;
    rs_en_i = 1'b1; rs_idx_i = 3'd0; rs_selector_i = 16'h2222;
    rs_base_i = 24'h222222; rs_limit_i = 16'h2222; rs_rights_i = 8'h92;
    tick();
    ld_en_i = 1'b0; rs_en_i = 1'b0; pmode_i = 1'b0;
    read_chk("R5 restore wins", 3'd0, 16'h2222, 24'h222222, 16'h2222, 8'h92);
  endtask

  // R6: rights seen for system tables
  task automatic t_sys_rights();
    do_restore(3'd4, 16'h0, 24'h000000, 16'hFFFF, 8'h00);
    read_chk("R6 GDT", 3'd4, 16'h0, 24'h000000, 16'hFFFF, 8'hFF);
    do_restore(3'd5, 16'h0, 24'h000000, 16'hFFFF, 8'h00);
    read_chk("R6 LDT invalid", 3'd5, 16'h0, 24'h000000, 16'hFFFF, 8'h7F);
    do_restore(3'd5, 16'h0, 24'h000000, 16'hFFFF, 8'h80);
    read_chk("R6 LDT valid", 3'd5, 16'h0, 24'h000000, 16'hFFFF, 8'hFF);
    do_restore(3'd7, 16'h0, 24'h000000, 16'h0067, 8'h00);
    read_chk("R6 TSS", 3'd7, 16'h0, 24'h000000, 16'h0067, 8'hFF);
  endtask

  // R8: validity faults
  task automatic t_valid();
    do_restore(3'd0, 16'h0, 24'h000000, 16'hFFFF, 8'h02);
    access_chk("R8 ES invalid", 3'd0, 16'h0010, 2'd0, 1'b1, 24'h0);
    do_restore(3'd5, 16'h0, 24'h000000, 16'hFFFF, 8'h00);
    access_chk("R8 LDT invalid", 3'd5, 16'h0010, 2'd0, 1'b1, 24'h0);
    access_chk("R8 TSS no valid bit", 3'd7, 16'h0000, 2'd1, 1'b0, 24'h000000);
    access_chk("R8 GDT no valid bit", 3'd4, 16'h0010, 2'd0, 1'b0, 24'h000010);
  endtask

  // R9: expand-up limit edges
  task automatic t_limit();
    do_restore(3'd0, 16'h0, 24'h001000, 16'h00FF, 8'h82);
    access_chk("R9 byte at limit",   3'd0, 16'h00FF, 2'd0, 1'b0, 24'h0010FF);
    access_chk("R9 word over limit", 3'd0, 16'h00FF, 2'd1, 1'b1, 24'h0);
    access_chk("R9 word at limit",   3'd0, 16'h00FE, 2'd1, 1'b0, 24'h0010FE);
    access_chk("R9 dword at limit",  3'd0, 16'h00FC, 2'd3, 1'b0, 24'h0010FC);
    access_chk("R9 dword over",      3'd0, 16'h00FD, 2'd3, 1'b1, 24'h0);
    access_chk("R9 TSS in",          3'd7, 16'h0066, 2'd1, 1'b0, 24'h000066);
    access_chk("R9 TSS over",        3'd7, 16'h0067, 2'd1, 1'b1, 24'h0);
    do_restore(3'd3, 16'h0, 24'h0, 16'hFFFF, 8'h92);
    access_chk("R9 top of 64K", 3'd3, 16'hFFFF, 2'd1, 1'b1, 24'h0);
  endtask

  // R10: expand-down data and code segments
  task automatic t_expdown();
    do_restore(3'd3, 16'h0, 24'h200000, 16'h0FFF, 8'h96);
    access_chk("R10 down at limit",  3'd3, 16'h0FFF, 2'd0, 1'b1, 24'h0);
    access_chk("R10 down above",     3'd3, 16'h1000, 2'd1, 1'b0, 24'h201000);
    access_chk("R10 down zero",      3'd3, 16'h0000, 2'd0, 1'b1, 24'h0);
    do_restore(3'd1, 16'h0, 24'h300000, 16'h0FFF, 8'h9E);
    access_chk("R10 code in",        3'd1, 16'h0FFF, 2'd0, 1'b0, 24'h300FFF);
    access_chk("R10 code over",      3'd1, 16'h1000, 2'd0, 1'b1, 24'h0);
  endtask

  // R11: wrap and same-edge ordering
  task automatic t_timing();
    do_restore(3'd2, 16'h0, 24'hFFFFF0, 16'hFFFF, 8'h92);
    access_chk("R11 wrap", 3'd2, 16'h0020, 2'd0, 1'b0, 24'h000010);
    do_restore(3'd0, 16'h0, 24'h001000, 16'h00FF, 8'h82);
    acc_en_i = 1'b1; acc_idx_i = 3'd0; acc_off_i = 16'h0010; acc_len_i = 2'd0;
    rs_en_i = 1'b1; rs_idx_i = 3'd0; rs_selector_i = 16'h0;
    rs_base_i = 24'h500000; rs_limit_i = 16'h00FF; rs_rights_i = 8'h82;
    tick();
    acc_en_i = 1'b0; rs_en_i = 1'b0;
    chk("R11 old state fault", 32'(acc_fault_o), 32'h0);
    chk("R11 old state lin", 32'(acc_lin_o), 32'h001010);
    tick();
    chk("R11 valid drops", 32'(acc_vld_o), 32'h0);
    access_chk("R11 new state", 3'd0, 16'h0010, 2'd0, 1'b0, 24'h500010);
  endtask

  initial begin
    rst_n = 1'b0; pmode_i = 1'b0;
    ld_en_i = 1'b0; rs_en_i = 1'b0; acc_en_i = 1'b0;
    ld_idx_i = '0; rs_idx_i = '0; acc_idx_i = '0; rd_idx_i = '0;
    ld_selector_i = '0; rs_selector_i = '0; ld_limit_i = '0; rs_limit_i = '0;
    acc_off_i = '0; ld_base_i = '0; rs_base_i = '0;
    ld_rights_i = '0; rs_rights_i = '0; acc_len_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    tick();
    t_reset();
    t_real_load();
    t_pm_load();
    t_priority();
    t_sys_rights();
    t_valid();
    t_limit();
    t_expdown();
    t_timing();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule